// File: doc/BRIEF.md
# Attack and Hold Pulse Timer

This block drives a two-phase actuator waveform. A start command raises the attack output for a programmed interval. When the interval ends, the hold output takes over, either as a steady high level or as a pulse-width-modulated waveform. The interval is counted in prescaled ticks. It is made of a number of coarse laps of 256 ticks each, followed by a fine phase that lasts the fine value plus one tick.

A repeat mode keeps the timer running without stopping. At the end of each interval the timer restarts, the attack output flips level and the PWM hold keeps running; this gives a steady blink for bench use. A stop command clears everything and returns the timer to idle. All settings arrive on parallel inputs. The interval values are captured at each start and at each restart.

Top module: `atk_hold_timer`

## Requirements
- R1: After reset, attack, hold and both state flag bits are 0.
- R2: Outside repeat mode, attack goes high the cycle after a start and stays high for exactly (coarse*256 + fine + 1) * D clock cycles, where D is the tick divisor.
- R3: A nonzero coarse value adds whole laps of 256 ticks ahead of the fine phase. With coarse 0 the fine phase begins at once.
- R4: Tick code 1 gives D=1, 2 gives D=8, 3 gives D=64, 4 gives D=256 and 5 gives D=1024. Codes 0, 6 and 7 produce no ticks, so a started interval never ends.
- R5: When an interval ends with repeat clear and pwm_mode clear, attack falls and hold becomes a steady 1.
- R6: When an interval ends with repeat clear and pwm_mode set, hold runs a PWM with period (top+1)*P cycles and high time (duty+1)*P cycles per period, for duty < top. Divider code d from 2 to 15 gives P = 2^(d-1), and codes 0 and 1 give P=1.
- R7: Stop forces attack, hold and the flags to 0 on the next clock edge and returns the timer to idle. Stop takes priority over a simultaneous start.
- R8: In repeat mode each interval end restarts the timer and inverts attack, so attack alternates high and low runs of equal length. PWM hold runs from the first interval end onward.
- R9: state_flags bit 0 equals attack. Bit 1 is 1 while hold is active, whether steady or PWM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins an interval |
| stop | input | 1 | One-cycle pulse that ends all activity |
| mode_repeat | input | 1 | Free-running restart mode |
| mode_pwm | input | 1 | Hold as PWM (1) or as a steady level (0) |
| tick_code | input | 3 | Tick prescaler select |
| coarse | input | 8 | Number of 256-tick laps |
| fine | input | 8 | Fine compare value |
| pwm_div_code | input | 4 | PWM clock divider select |
| pwm_top | input | 8 | PWM counter top value |
| pwm_duty | input | 8 | PWM clear compare value |
| attack | output | 1 | Attack drive |
| hold | output | 1 | Hold drive |
| state_flags | output | 2 | Bit 0 attack, bit 1 hold active |

## Verification
The assertions on the prescaler and PWM counter bounds assume that tick_code, pwm_div_code and pwm_top stay unchanged while the timer or the PWM is running. They also assume that start and stop are single-cycle pulses. The bench changes settings only while the block is idle, after a stop or before a start. It drives every command as a pulse lasting one clock. PWM duty is checked only for duty below top, and it is measured over whole periods after the first wrap.

// File: rtl/aht_pkg.sv
package aht_pkg;

  localparam int TICK_DIV_W = 11;
  localparam int PWM_DIV_W  = 15;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_COARSE = 2'd1,
    PH_FINE   = 2'd2
  } phase_t;

  // Tick divisor from its select code; zero means "no ticks".
  function automatic logic [TICK_DIV_W-1:0] tick_divisor(input logic [2:0] code);
    case (code)
      3'd1:    return TICK_DIV_W'(1);
      3'd2:    return TICK_DIV_W'(8);
      3'd3:    return TICK_DIV_W'(64);
      3'd4:    return TICK_DIV_W'(256);
      3'd5:    return TICK_DIV_W'(1024);
      default: return '0;
    endcase
  endfunction

  // PWM step divisor: 2^(code-1) for code >= 2, otherwise 1.
  function automatic logic [PWM_DIV_W-1:0] pwm_divisor(input logic [3:0] code);
    if (code < 4'd2) return PWM_DIV_W'(1);
    return PWM_DIV_W'(1) << (code - 4'd1);
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import aht_pkg::*;
#(
  parameter int DIV_W = TICK_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] pc;
  logic             div_ok;

  assign div_ok = (divisor != '0);
  assign tick   = run && div_ok && (pc == divisor - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                      pc <= '0;
    else if (clear || !run || !div_ok) pc <= '0;
    else if (tick)                   pc <= '0;
    else                             pc <= pc + DIV_W'(1);
  end

  // R4: the phase counter never passes the selected divisor
  p_pc_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && div_ok) |-> (pc < divisor));

  // R4: an invalid code never produces a tick
  p_no_tick_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !div_ok |-> !tick);

endmodule

// File: rtl/interval_fsm.sv
module interval_fsm
  import aht_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             tick,
  input  logic [CNT_W-1:0] coarse_in,
  input  logic [CNT_W-1:0] fine_in,
  input  logic             mode_repeat,
  input  logic             mode_pwm,
  output logic             attack,
  output logic             hold_steady,
  output logic             pwm_en,
  output logic             running,
  output logic             restart
);
  phase_t           phase;
  logic [CNT_W-1:0] tcnt, laps, coarse_q, fine_q, cmp;
  logic             match, lap_last, interval_end;

  assign cmp          = (phase == PH_COARSE) ? '1 : fine_q;
  assign match        = tick && (tcnt == cmp);
  assign lap_last     = match && (phase == PH_COARSE) &&
                        (({1'b0, laps} + (CNT_W+1)'(1)) >= {1'b0, coarse_q});
  assign interval_end = match && (phase == PH_FINE);
  assign restart      = !stop && (start || (interval_end && mode_repeat));
  assign running      = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n || stop) begin
      phase       <= PH_IDLE;
      attack      <= 1'b0;
      hold_steady <= 1'b0;
      pwm_en      <= 1'b0;
      tcnt        <= '0;
      laps        <= '0;
      coarse_q    <= '0;
      fine_q      <= '0;
    end else if (start) begin
      phase       <= (coarse_in != '0) ? PH_COARSE : PH_FINE;
      attack      <= 1'b1;
      hold_steady <= 1'b0;
      pwm_en      <= 1'b0;
      tcnt        <= '0;
      laps        <= '0;
      coarse_q    <= coarse_in;
      fine_q      <= fine_in;
    end else if (match) begin
      tcnt <= '0;
      if (phase == PH_COARSE) begin
        laps <= laps + CNT_W'(1);
        if (lap_last) phase <= PH_FINE;
      end else if (mode_repeat) begin
        phase       <= (coarse_in != '0) ? PH_COARSE : PH_FINE;
        attack      <= ~attack;
        hold_steady <= 1'b0;
        pwm_en      <= 1'b1;
        laps        <= '0;
        coarse_q    <= coarse_in;
        fine_q      <= fine_in;
      end else begin
        phase       <= PH_IDLE;
        attack      <= 1'b0;
        hold_steady <= !mode_pwm;
        pwm_en      <= mode_pwm;
      end
    end else if (tick) begin
      tcnt <= tcnt + CNT_W'(1);
    end
  end

  p_stop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (phase == PH_IDLE) && !attack && !hold_steady && !pwm_en);

  p_lap_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_COARSE) |-> (laps < coarse_q));

  p_tick_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (tcnt <= cmp));

  p_idle_no_attack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !attack);

  p_hold_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hold_steady && pwm_en));

  p_end_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (interval_end && !mode_repeat && !stop && !start) |=> (!attack && !running));

  p_repeat_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (interval_end && mode_repeat && !stop && !start) |=> (attack != $past(attack)) && pwm_en);

endmodule

// File: rtl/hold_pwm.sv
module hold_pwm
  import aht_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_W = PWM_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [3:0]       div_code,
  input  logic [CNT_W-1:0] top,
  input  logic [CNT_W-1:0] duty,
  output logic             pwm_out
);
  logic [DIV_W-1:0] divisor, dcnt;
  logic [CNT_W-1:0] pcnt;
  logic             step, wrap, duty_hit;

  assign divisor  = pwm_divisor(div_code);
  assign step     = en && (dcnt == divisor - DIV_W'(1));
  assign wrap     = step && (pcnt >= top);
  assign duty_hit = step && (pcnt == duty);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      dcnt    <= '0;
      pcnt    <= '0;
      pwm_out <= 1'b0;
    end else begin
      dcnt <= step ? '0 : dcnt + DIV_W'(1);
      if (step) pcnt <= wrap ? '0 : pcnt + CNT_W'(1);
      if (wrap)          pwm_out <= 1'b1;
      else if (duty_hit) pwm_out <= 1'b0;
    end
  end

  p_div_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (dcnt < divisor));

  p_pwm_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_out);

  p_wrap_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wrap) |=> (pwm_out || !en));

endmodule

// File: rtl/atk_hold_timer.sv
module atk_hold_timer
  import aht_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             mode_repeat,
  input  logic             mode_pwm,
  input  logic [2:0]       tick_code,
  input  logic [CNT_W-1:0] coarse,
  input  logic [CNT_W-1:0] fine,
  input  logic [3:0]       pwm_div_code,
  input  logic [CNT_W-1:0] pwm_top,
  input  logic [CNT_W-1:0] pwm_duty,
  output logic             attack,
  output logic             hold,
  output logic [1:0]       state_flags
);
  logic tick, running, restart, hold_steady, pwm_en, pwm_out;

  tick_prescaler #(.DIV_W(TICK_DIV_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (restart),
    .run     (running),
    .divisor (tick_divisor(tick_code)),
    .tick    (tick)
  );

  interval_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .stop        (stop),
    .tick        (tick),
    .coarse_in   (coarse),
    .fine_in     (fine),
    .mode_repeat (mode_repeat),
    .mode_pwm    (mode_pwm),
    .attack      (attack),
    .hold_steady (hold_steady),
    .pwm_en      (pwm_en),
    .running     (running),
    .restart     (restart)
  );

  hold_pwm #(.CNT_W(CNT_W), .DIV_W(PWM_DIV_W)) u_pwm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (pwm_en),
    .div_code (pwm_div_code),
    .top      (pwm_top),
    .duty     (pwm_duty),
    .pwm_out  (pwm_out)
  );

  assign hold        = hold_steady || (pwm_en && pwm_out);
  assign state_flags = {hold_steady || pwm_en, attack};

  p_flag_attack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state_flags[0] == attack);

  p_hold_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> state_flags[1]);

endmodule

// File: tb/tb_atk_hold_timer.sv
`timescale 1ns/1ps
module tb_atk_hold_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, stop = 1'b0, mode_repeat = 1'b0, mode_pwm = 1'b0;
  logic [2:0] tick_code = 3'd1;
  logic [7:0] coarse = 8'd0, fine = 8'd0, pwm_top = 8'd9, pwm_duty = 8'd3;
  logic [3:0] pwm_div_code = 4'd2;
  logic       attack, hold;
  logic [1:0] state_flags;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  atk_hold_timer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .mode_repeat(mode_repeat), .mode_pwm(mode_pwm), .tick_code(tick_code),
    .coarse(coarse), .fine(fine), .pwm_div_code(pwm_div_code),
    .pwm_top(pwm_top), .pwm_duty(pwm_duty),
    .attack(attack), .hold(hold), .state_flags(state_flags)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
  endtask

  // counts negedge samples while attack equals lvl
  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (attack == lvl && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // divisor per tick code, written out as the requirement states
  function automatic int exp_div(input int code);
    int t[6] = '{0, 1, 8, 64, 256, 1024};
    return t[code];
  endfunction

  task automatic t_reset();
    chk("R1 attack", attack, 0);
    chk("R1 hold", hold, 0);
    chk("R1 flags", state_flags, 0);
  endtask

  task automatic t_length(input int code, input int c, input int f, input string req);
    int n;
    mode_repeat = 0; mode_pwm = 0;
    tick_code = 3'(code); coarse = 8'(c); fine = 8'(f);
    pulse_start();
    run_len(1'b1, n);
    chk(req, n, (c * 256 + f + 1) * exp_div(code));
    chk("R5 hold steady", hold, 1);
    chk("R9 flags after end", state_flags, 2);
    pulse_stop();
  endtask

  task automatic t_freeze(input int code);
    mode_repeat = 0; mode_pwm = 0;
    tick_code = 3'(code); coarse = 0; fine = 0;
    pulse_start();
    repeat (300) @(negedge clk);
    chk("R4 invalid code holds attack", attack, 1);
    chk("R9 flags attack only", state_flags, 1);
    pulse_stop();
    chk("R7 stop clears attack", attack, 0);
    chk("R7 stop clears flags", state_flags, 0);
  endtask

  task automatic t_pwm(input int d, input int top, input int duty);
    int hi;
    int p;
    p = (d < 2) ? 1 : (1 << (d - 1));
    mode_repeat = 0; mode_pwm = 1;
    tick_code = 1; coarse = 0; fine = 2;
    pwm_div_code = 4'(d); pwm_top = 8'(top); pwm_duty = 8'(duty);
    pulse_start();
    run_len(1'b1, hi);
    chk("R9 flags pwm hold", state_flags, 2);
    repeat (3 * (top + 1) * p) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 2 * (top + 1) * p; i++) begin
      if (hold) hi++;
      @(negedge clk);
    end
    chk("R6 pwm high cycles", hi, 2 * (duty + 1) * p);
    pulse_stop();
    hi = 0;
    for (int i = 0; i < 50; i++) begin
      if (hold) hi++;
      @(negedge clk);
    end
    chk("R7 hold silent after stop", hi, 0);
    chk("R7 flags after stop", state_flags, 0);
  endtask

  task automatic t_repeat();
    int n;
    mode_repeat = 1; mode_pwm = 0;
    tick_code = 1; coarse = 0; fine = 4;
    pwm_div_code = 2; pwm_top = 9; pwm_duty = 3;
    pulse_start();
    run_len(1'b1, n);
    chk("R8 first high run", n, 5);
    chk("R8 pwm hold flag", state_flags[1], 1);
    run_len(1'b0, n);
    chk("R8 low run", n, 5);
    run_len(1'b1, n);
    chk("R8 second high run", n, 5);
    pulse_stop();
    chk("R7 stop ends repeat", attack, 0);
    repeat (20) @(negedge clk);
    chk("R7 stays idle", attack, 0);
  endtask

  task automatic t_stop_priority();
    mode_repeat = 0; mode_pwm = 0;
    tick_code = 1; coarse = 0; fine = 200;
    pulse_start();
    repeat (10) @(negedge clk);
    pulse_stop();
    chk("R7 stop mid attack", attack, 0);
    @(negedge clk) begin start = 1; stop = 1; end
    @(negedge clk) begin start = 0; stop = 0; end
    chk("R7 stop beats start", attack, 0);
    chk("R7 flags zero", state_flags, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_length(1, 0, 9, "R2 fine only");
    t_length(1, 2, 5, "R3 two laps");
    t_length(1, 1, 0, "R3 one lap");
    t_length(2, 0, 3, "R4 div 8");
    t_length(3, 0, 1, "R4 div 64");
    t_length(4, 0, 0, "R4 div 256");
    t_length(5, 0, 0, "R4 div 1024");
    t_freeze(0);
    t_freeze(6);
    t_pwm(2, 9, 3);
    t_pwm(3, 4, 1);
    t_pwm(1, 3, 0);
    t_repeat();
    t_stop_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule